// File: doc/BRIEF.md
# Pipelined Matching Request Distributor

This block sits in front of a bank of K matching engines that serve an N-port input-queued crossbar with one virtual output queue (VOQ) per input/output pair. Each matching engine needs K slots to compute one matching. The engines start in staggered slots, so exactly one of them delivers a finished matching in every slot. The block holds one backlog counter per pair, for requests that no engine has received yet. It also holds one request flag per pair per engine, for a request that engine currently owns.

One clock cycle is one slot. At each clock edge the block does three things. It applies the result of the engine that finishes in the slot now ending, and turns every valid match into a one-slot transfer grant for the next slot. It then reloads that same engine from the backlog counters, at most one request per pair. Finally it adds the arrival strobes to the counters. Arrival strobes, match results and grants all move at the fixed slot cadence and cannot be held off. The block therefore has no ready signals. A match result is qualified by `match_vld_i`, and the grant output is qualified by `grant_vld_o`.

Bit layout: pair p = i*N + j (input i, output j). Flag of engine k for pair p is bit `k*N*N + p` of `flags_o`. The counter of pair p is `cnt_o[p*CW +: CW]`.

Top module: `pipe_match_feeder`

## Requirements
- R1: While reset is asserted, and just after it is released, all counters, flags, grants and overflow bits are 0, `load_sel_o` is one-hot with bit K-1 set, and `fin_sel_o` is one-hot with bit 0 set.
- R2: A strobe on `arr_i[p]` increments counter p at the next edge. If a hand-off from pair p happens at the same edge, the two cancel and the counter is unchanged.
- R3: `load_sel_o` is always one-hot. At each edge it moves to the index shown by `fin_sel_o` before the edge, so engines are loaded in the cyclic order 0, 1, …, K-1. The engine loaded in slot t delivers its result in slot t+K-1.
- R4: At each edge, the engine named by `fin_sel_o` takes a request for pair p when two conditions hold: counter p was nonzero before the edge, and its flag for p is 0 once the match has been applied. Taking the request sets that flag and decrements counter p.
- R5: The flags of every engine other than the one named by `fin_sel_o` do not change at the edge.
- R6: If `match_vld_i` is high and `match_i[p]` is set while the finishing engine's flag for p is 1, that flag is cleared. It may be reloaded at the same edge under R4. `grant_o[p]` is then high for exactly the next slot, and `grant_vld_o` is the OR of `grant_o`.
- R7: A match bit is ignored when `match_vld_i` is low, or when the finishing engine's flag for that pair is 0. In either case no grant is produced and no flag is cleared.
- R8: A flagged pair that is not matched keeps its flag, and the request carries over to that engine's next round.
- R9: A counter saturates at 2^CW-1. An arrival at a full counter with no hand-off at the same edge is dropped. The counter holds, and `ovf_o[p]` is high for one slot.
- R10: For every pair, accepted arrivals minus grants always equals the counter plus the sum of its K flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_i | input | N*N | Cell-arrival strobe per VOQ |
| match_vld_i | input | 1 | Result of the finishing engine is present |
| match_i | input | N*N | Matched pairs from the finishing engine |
| load_sel_o | output | K | One-hot: engine loaded at the start of this slot |
| fin_sel_o | output | K | One-hot: engine whose result is due in this slot |
| flags_o | output | K*N*N | Request flags of all engines |
| cnt_o | output | N*N*CW | Backlog counters |
| grant_o | output | N*N | Transfer grants for this slot |
| grant_vld_o | output | 1 | Any grant bit set |
| ovf_o | output | N*N | Arrival dropped at a full counter (one slot) |

## Verification
The bench goes after four corner cases.

- **Clear and reload at one edge.** The finishing engine is also the one being reloaded. A design that reloads before it clears loses a request, or grants one twice, and the occupancy identity then breaks.
- **Stale or unqualified match bits.** Match bits arrive for pairs the finishing engine never flagged, or while the valid strobe is low. A design that trusts them grants cells that do not exist.
- **Counter saturation.** One VOQ is flooded until its counter fills. A counter that wraps, or one that fails to flag the drop, shows up in the counter value and in the overflow bit.
- **Carry-over and drain.** An unmatched pair must keep its flag, and every queued cell must leave with one grant per finishing engine.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  // index of the slot that follows s in a ring of k slots
  function automatic int unsigned slot_after(int unsigned s, int unsigned k);
    return (s + 1 >= k) ? 0 : s + 1;
  endfunction
endpackage

// File: rtl/pmd_slot_ring.sv
module pmd_slot_ring
  import pmd_pkg::*;
#(
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [K-1:0] load_oh_o,
  output logic [K-1:0] fin_oh_o
);
  localparam int SW = (K > 1) ? $clog2(K) : 1;

  logic [SW-1:0] cur_q;
  logic [SW-1:0] nxt;

  always_comb nxt = SW'(slot_after(int'(cur_q), K));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= SW'(K - 1);
    else        cur_q <= nxt;
  end

  for (genvar k = 0; k < K; k++) begin : g_sel
    assign load_oh_o[k] = (cur_q == SW'(k));
    assign fin_oh_o[k]  = (nxt == SW'(k));
  end
endmodule

// File: rtl/pmd_pair_slot.sv
module pmd_pair_slot #(
  parameter int K  = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arr_i,
  input  logic          hit_req_i,
  input  logic [K-1:0]  fin_oh_i,
  output logic [K-1:0]  flags_o,
  output logic [CW-1:0] cnt_o,
  output logic          grant_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [K-1:0]  flags_q, flags_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          held, hit, keep, take, drop, accept;

  always_comb begin
    held   = |(flags_q & fin_oh_i);
    hit    = hit_req_i & held;
    keep   = held & ~hit;
    take   = (cnt_q != '0) & ~keep;
    drop   = arr_i & ~take & (cnt_q == CMAX);
    accept = arr_i & ~drop;
    for (int k = 0; k < K; k++)
      flags_d[k] = fin_oh_i[k] ? (keep | take) : flags_q[k];
    unique case ({accept, take})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cnt_q   <= '0;
      grant_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      cnt_q   <= cnt_d;
      grant_o <= hit;
      ovf_o   <= drop;
    end
  end

  assign flags_o = flags_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/pipe_match_feeder.sv
module pipe_match_feeder #(
  parameter int N  = 4,
  parameter int K  = 3,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*N-1:0]  arr_i,
  input  logic            match_vld_i,
  input  logic [N*N-1:0]  match_i,
  output logic [K-1:0]    load_sel_o,
  output logic [K-1:0]    fin_sel_o,
  output logic [K*N*N-1:0] flags_o,
  output logic [N*N*CW-1:0] cnt_o,
  output logic [N*N-1:0]  grant_o,
  output logic            grant_vld_o,
  output logic [N*N-1:0]  ovf_o
);
  localparam int NN = N * N;

  logic [K-1:0] fin_oh;

  pmd_slot_ring #(.K(K)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_oh_o (load_sel_o),
    .fin_oh_o  (fin_oh)
  );
  assign fin_sel_o = fin_oh;

  for (genvar p = 0; p < NN; p++) begin : g_pair
    logic [K-1:0] fp;
    pmd_pair_slot #(.K(K), .CW(CW)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .arr_i     (arr_i[p]),
      .hit_req_i (match_vld_i & match_i[p]),
      .fin_oh_i  (fin_oh),
      .flags_o   (fp),
      .cnt_o     (cnt_o[p*CW +: CW]),
      .grant_o   (grant_o[p]),
      .ovf_o     (ovf_o[p])
    );
    for (genvar k = 0; k < K; k++) begin : g_fl
      assign flags_o[k*NN + p] = fp[k];
    end
  end

  assign grant_vld_o = |grant_o;
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int N  = 4,
  parameter int K  = 3,
  parameter int CW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N*N-1:0]    arr_i,
  input logic              match_vld_i,
  input logic [N*N-1:0]    match_i,
  input logic [K-1:0]      load_sel_o,
  input logic [K-1:0]      fin_sel_o,
  input logic [K*N*N-1:0]  flags_o,
  input logic [N*N*CW-1:0] cnt_o,
  input logic [N*N-1:0]    grant_o,
  input logic [N*N-1:0]    ovf_o
);
  localparam int NN = N * N;
  localparam logic [CW-1:0] CMAX = '1;

  assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(load_sel_o) == 1);
  assert_load_follows_fin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> load_sel_o == $past(fin_sel_o));

  for (genvar p = 0; p < NN; p++) begin : g_p
    logic [K-1:0] fv;
    for (genvar k = 0; k < K; k++) begin : g_k
      assign fv[k] = flags_o[k*NN + p];
      assert_other_engines_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fin_sel_o[k]) |-> $stable(flags_o[k*NN + p]));
    end
    assert_grant_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[p] |-> $past(match_vld_i && match_i[p] && ((fv & fin_sel_o) != '0)));
    assert_grant_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[p] && $past(cnt_o[p*CW +: CW]) == '0) |-> ((fv & $past(fin_sel_o)) == '0));
    assert_invalid_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(match_vld_i) |-> !grant_o[p]);
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[p] |-> cnt_o[p*CW +: CW] == CMAX);
  end
endmodule

bind pipe_match_feeder pmd_checker #(.N(N), .K(K), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arr_i       (arr_i),
  .match_vld_i (match_vld_i),
  .match_i     (match_i),
  .load_sel_o  (load_sel_o),
  .fin_sel_o   (fin_sel_o),
  .flags_o     (flags_o),
  .cnt_o       (cnt_o),
  .grant_o     (grant_o),
  .ovf_o       (ovf_o)
);

// File: tb/sim_pipe_match_feeder.sv
module sim_pipe_match_feeder;
  localparam int N = 4, K = 3, CW = 4, NN = N * N;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NN-1:0] arr_i = '0, match_i = '0;
  logic match_vld_i = 1'b0;
  logic [K-1:0] load_sel_o, fin_sel_o;
  logic [K*NN-1:0] flags_o;
  logic [NN*CW-1:0] cnt_o;
  logic [NN-1:0] grant_o, ovf_o;
  logic grant_vld_o;

  always #2 clk = ~clk;

  pipe_match_feeder #(.N(N), .K(K), .CW(CW)) u0 (.*);

  int total = 0, fails = 0;
  bit done = 1'b0;
  int mC[NN];
  bit mF[K][NN];
  int occ[NN];
  int ms;

  // rows: {arrivals, match valid, match mask}
  localparam logic [32:0] VEC [16] = '{
    {16'h0001, 1'b0, 16'h0000}, {16'h8421, 1'b0, 16'h0000},
    {16'hFFFF, 1'b0, 16'h0000}, {16'h0001, 1'b1, 16'hFFFF},
    {16'h1248, 1'b1, 16'h0001}, {16'h0000, 1'b1, 16'h8421},
    {16'hF0F0, 1'b1, 16'h0F0F}, {16'h0000, 1'b0, 16'hFFFF},
    {16'h3333, 1'b1, 16'hAAAA}, {16'h0000, 1'b1, 16'h5555},
    {16'hFFFF, 1'b1, 16'hFFFF}, {16'h0101, 1'b1, 16'h1111},
    {16'h0000, 1'b1, 16'hFFFF}, {16'h0000, 1'b1, 16'hFFFF},
    {16'h0000, 1'b1, 16'hFFFF}, {16'h0000, 1'b1, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NN-1:0] a, input logic v, input logic [NN-1:0] m);
    logic [NN-1:0] eg, eo, bad;
    logic [K*NN-1:0] ef;
    logic [NN*CW-1:0] ec;
    int nx;
    arr_i = a; match_vld_i = v; match_i = m;
    nx = (ms + 1 >= K) ? 0 : ms + 1;
    for (int p = 0; p < NN; p++) begin
      bit hit, keep, take, drop;
      hit  = v && m[p] && mF[nx][p];
      keep = mF[nx][p] && !hit;
      take = (mC[p] != 0) && !keep;
      drop = a[p] && !take && (mC[p] == CMAX);
      mF[nx][p] = keep || take;
      mC[p] = mC[p] - int'(take) + int'(a[p] && !drop);
      occ[p] = occ[p] + int'(a[p] && !drop) - int'(hit);
      eg[p] = hit;
      eo[p] = drop;
    end
    ms = nx;
    for (int p = 0; p < NN; p++) begin
      ec[p*CW +: CW] = CW'(mC[p]);
      for (int k = 0; k < K; k++) ef[k*NN + p] = mF[k][p];
    end
    @(posedge clk); #1;
    chk(cnt_o == ec, "R2/R4 counters", 64'(cnt_o), 64'(ec));
    chk(flags_o == ef, "R4/R5/R8 flags", 64'(flags_o), 64'(ef));
    chk(grant_o == eg && grant_vld_o == (eg != '0), "R6/R7 grants", 64'(grant_o), 64'(eg));
    chk(ovf_o == eo, "R9 overflow", 64'(ovf_o), 64'(eo));
    chk(load_sel_o == K'(1 << ms), "R3 load select", 64'(load_sel_o), 64'(1 << ms));
    for (int p = 0; p < NN; p++) begin
      int sf = 0;
      for (int k = 0; k < K; k++) sf += int'(flags_o[k*NN + p]);
      bad[p] = (occ[p] != int'(cnt_o[p*CW +: CW]) + sf);
    end
    chk(bad == '0, "R10 occupancy identity", 64'(bad), 64'(0));
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    ms = K - 1;
    for (int p = 0; p < NN; p++) begin
      mC[p] = 0; occ[p] = 0;
      for (int k = 0; k < K; k++) mF[k][p] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(cnt_o == '0 && flags_o == '0 && grant_o == '0 && ovf_o == '0, "R1 cleared state",
        64'(cnt_o | 64'(flags_o)), 64'(0));
    chk(load_sel_o == K'(1 << (K-1)) && fin_sel_o == K'(1), "R1 select reset",
        64'({load_sel_o, fin_sel_o}), 64'({K'(1 << (K-1)), K'(1)}));
    @(negedge clk); rst_n = 1'b1;

    for (int r = 0; r < 16; r++) step(VEC[r][32:17], VEC[r][16], VEC[r][15:0]);

    // R9: flood pair 5 with no matches
    for (int r = 0; r < 22; r++) step(NN'(1 << 5), 1'b0, '0);
    chk(ovf_o[5] == 1'b1 && cnt_o[5*CW +: CW] == CW'(CMAX), "R9 saturated pair 5",
        64'(cnt_o[5*CW +: CW]), 64'(CMAX));

    // R8: matched everything except pair 5; its flags stay set
    step('0, 1'b1, ~NN'(1 << 5));
    chk(flags_o[5] && flags_o[NN+5] && flags_o[2*NN+5], "R8 carry-over",
        64'({flags_o[2*NN+5], flags_o[NN+5], flags_o[5]}), 64'(7));

    // R7: match bits while valid low are ignored
    step('0, 1'b0, '1);
    chk(grant_o == '0, "R7 invalid result ignored", 64'(grant_o), 64'(0));

    // drain everything
    for (int r = 0; r < 30; r++) step('0, 1'b1, '1);
    chk(cnt_o == '0 && flags_o == '0, "R10 fully drained", 64'(cnt_o), 64'(0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule